// File: doc/BRIEF.md
# Four-Pin Shared-Function I/O Port

This block is a four-pin general-purpose I/O port on a simple memory-mapped register bus. Software sets each pin's direction and output level, and reads back the pin levels. The registers are a direction register that can only be written, an output-level register that can be read and written, and a pin-level register that can only be read. Register writes take effect on the clock edge that samples the write strobe. Reads are combinational and have no side effects.

Three pins can be taken over by a serial peripheral: pin 0 carries transmit data, pin 1 receive data and pin 2 a clock in either direction. Pin 3 also feeds a converter-trigger input. Both the serial peripheral and the converter are outside this block. They appear only as enable and data signals.

A small mode state machine tracks four conditions: normal running (ST_RUN), manual reset (ST_MRST), software standby (ST_SSTBY) and hardware standby (ST_HSTBY). On every clock it takes the highest-priority request present. Hardware standby wins, then manual reset, then software standby. With no request it goes to ST_RUN. This gives the transitions ST_RUN→ST_HSTBY/ST_MRST/ST_SSTBY, ST_SSTBY→ST_HSTBY/ST_MRST/ST_RUN, ST_MRST→ST_HSTBY/ST_SSTBY/ST_RUN and ST_HSTBY→ST_MRST/ST_SSTBY/ST_RUN. An asynchronous power-on reset puts the machine in ST_RUN.

Top module: `mux_gpio_port`

## Requirements
- R1: After power-on reset, all direction bits and output-level bits are 0, no pin is driven (pin_oe = 0), and a read of the output-level register returns 8'hF0.
- R2: A direction bit of 1 makes its pin an output (pin_oe bit high), and a 0 makes it an input. When no serial override applies, pin_out equals the output-level bits.
- R3: A read at the direction offset (16'hFEB4) always returns the fixed pattern 8'hFF and leaves the direction state and pin_oe unchanged.
- R4: Bits 7 to 4 of every register read back as 1, and writes to them have no effect.
- R5: The output-level register at 16'hFF64 holds the low four bits written to it and returns them in bits 3 to 0. Writes to any address other than the two writable offsets change nothing.
- R6: A read at the pin-level offset (16'hFF54) returns, per bit, the output-level bit for an output pin and the pin level synchronized through two flops for an input pin.
- R7: In ST_RUN with the transmit enable high, pin 0 is driven (pin_oe[0] = 1) with the transmit data, whatever its direction bit.
- R8: In ST_RUN with the serial clock set as an output, pin 2 is driven with the serial clock level, whatever its direction bit.
- R9: sci_rxd, sci_clk_in and conv_trig show the levels of pins 1, 2 and 3 after the two-flop synchronizer.
- R10: In ST_MRST the output-level bits clear, the direction bits keep their values, serial overrides are off and register writes are ignored.
- R11: In ST_SSTBY the direction and output-level bits keep their values, serial overrides are off and register writes are ignored.
- R12: From the first clock after hardware standby is sampled, no pin is driven. While in ST_HSTBY the direction and output-level bits clear, so pins stay undriven after the block leaves it.
- R13: Mode priority is hardware standby over manual reset over software standby. With manual reset and software standby both requested, the output-level bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| manual_rst | input | 1 | Manual reset request |
| sw_stby | input | 1 | Software standby request |
| hw_stby | input | 1 | Hardware standby request |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (1 = write, 0 = read) |
| bus_addr | input | 16 | Lower address bits of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 4 | Levels seen on the pads |
| pin_out | output | 4 | Levels to drive on the pads |
| pin_oe | output | 4 | Pad output enables |
| sci_tx_en | input | 1 | Serial transmitter enabled |
| sci_txd | input | 1 | Serial transmit data |
| sci_clk_oe | input | 1 | Serial clock is an output |
| sci_clk_out | input | 1 | Serial clock level when it is an output |
| sci_rxd | output | 1 | Synchronized level of pin 1 |
| sci_clk_in | output | 1 | Synchronized level of pin 2 |
| conv_trig | output | 1 | Synchronized level of pin 3 |

## Verification
The bench builds the port with its default parameters: four pins, 8-bit registers, 16-bit offsets at their standard values and a two-stage synchronizer. This puts the reserved upper nibble, both serial override pins and the exact two-cycle input latency within reach. The bench steps through every mode, including two requests at once, and checks that the direction bits are retained or cleared through each mode by looking at pin_oe.

// File: rtl/gp_port_pkg.sv
package gp_port_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_MRST  = 2'd1,
        ST_SSTBY = 2'd2,
        ST_HSTBY = 2'd3
    } gp_mode_e;

    localparam logic [15:0] OFS_DIR = 16'hFEB4;
    localparam logic [15:0] OFS_DAT = 16'hFF64;
    localparam logic [15:0] OFS_PIN = 16'hFF54;
endpackage

// File: rtl/gp_mode_fsm.sv
module gp_mode_fsm
    import gp_port_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     hw_stby,
    input  logic     manual_rst,
    input  logic     sw_stby,
    output gp_mode_e mode,
    output logic     clr_dir,
    output logic     clr_dat,
    output logic     wr_ok,
    output logic     ovr_ok
);
    gp_mode_e mode_nx;

    // Requests are taken by fixed priority from any state.
    always_comb begin
        mode_nx = mode;
        unique case (mode)
            ST_RUN, ST_SSTBY, ST_MRST, ST_HSTBY: begin
                if (hw_stby)         mode_nx = ST_HSTBY;
                else if (manual_rst) mode_nx = ST_MRST;
                else if (sw_stby)    mode_nx = ST_SSTBY;
                else                 mode_nx = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) mode <= ST_RUN;
        else        mode <= mode_nx;
    end

    always_comb begin
        clr_dir = 1'b0;
        clr_dat = 1'b0;
        wr_ok   = 1'b0;
        ovr_ok  = 1'b0;
        unique case (mode)
            ST_RUN:   begin wr_ok = 1'b1; ovr_ok = 1'b1; end
            ST_SSTBY: ;
            ST_MRST:  clr_dat = 1'b1;
            ST_HSTBY: begin clr_dir = 1'b1; clr_dat = 1'b1; end
        endcase
    end
endmodule

// File: rtl/gp_sync.sv
module gp_sync #(
    parameter int NPIN   = 4,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic [NPIN-1:0] d,
    output logic [NPIN-1:0] q
);
    logic [NPIN-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gp_regs.sv
module gp_regs #(
    parameter int          NPIN    = 4,
    parameter int          DW      = 8,
    parameter int          AW      = 16,
    parameter logic [AW-1:0] A_DIR = 16'hFEB4,
    parameter logic [AW-1:0] A_DAT = 16'hFF64,
    parameter logic [AW-1:0] A_PIN = 16'hFF54
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            clr_dir,
    input  logic            clr_dat,
    input  logic            wr_ok,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [NPIN-1:0] pin_sync,
    output logic [DW-1:0]   bus_rdata,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] dat_q
);
    localparam int RSV = DW - NPIN;
    localparam logic [RSV-1:0] RSV_ONES = '1;

    logic wr_en;
    logic [NPIN-1:0] pin_view;

    assign wr_en    = wr_ok && bus_sel && bus_wr;
    assign pin_view = (dir_q & dat_q) | (~dir_q & pin_sync);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else begin
            if (clr_dir)                          dir_q <= '0;
            else if (wr_en && bus_addr == A_DIR)  dir_q <= bus_wdata[NPIN-1:0];
            if (clr_dat)                          dat_q <= '0;
            else if (wr_en && bus_addr == A_DAT)  dat_q <= bus_wdata[NPIN-1:0];
        end
    end

    always_comb begin
        if (bus_addr == A_DAT)      bus_rdata = {RSV_ONES, dat_q};
        else if (bus_addr == A_PIN) bus_rdata = {RSV_ONES, pin_view};
        else                        bus_rdata = '1;
    end
endmodule

// File: rtl/gp_pinmux.sv
module gp_pinmux #(
    parameter int NPIN    = 4,
    parameter int TX_PIN  = 0,
    parameter int CLK_PIN = 2
) (
    input  logic            ovr_ok,
    input  logic            hstby,
    input  logic [NPIN-1:0] dir_q,
    input  logic [NPIN-1:0] dat_q,
    input  logic            sci_tx_en,
    input  logic            sci_txd,
    input  logic            sci_clk_oe,
    input  logic            sci_clk_out,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe
);
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        if (p == TX_PIN) begin : g_tx
            assign pin_oe[p]  = !hstby && ((ovr_ok && sci_tx_en) || dir_q[p]);
            assign pin_out[p] = (ovr_ok && sci_tx_en) ? sci_txd : dat_q[p];
        end else if (p == CLK_PIN) begin : g_ck
            assign pin_oe[p]  = !hstby && ((ovr_ok && sci_clk_oe) || dir_q[p]);
            assign pin_out[p] = (ovr_ok && sci_clk_oe) ? sci_clk_out : dat_q[p];
        end else begin : g_gp
            assign pin_oe[p]  = !hstby && dir_q[p];
            assign pin_out[p] = dat_q[p];
        end
    end
endmodule

// File: rtl/mux_gpio_port.sv
module mux_gpio_port
    import gp_port_pkg::*;
#(
    parameter int              NPIN     = 4,
    parameter int              DW       = 8,
    parameter int              AW       = 16,
    parameter int              SYNC_STG = 2,
    parameter logic [AW-1:0]   A_DIR    = OFS_DIR,
    parameter logic [AW-1:0]   A_DAT    = OFS_DAT,
    parameter logic [AW-1:0]   A_PIN    = OFS_PIN
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            manual_rst,
    input  logic            sw_stby,
    input  logic            hw_stby,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    input  logic            sci_tx_en,
    input  logic            sci_txd,
    input  logic            sci_clk_oe,
    input  logic            sci_clk_out,
    output logic            sci_rxd,
    output logic            sci_clk_in,
    output logic            conv_trig
);
    localparam int RX_PIN = 1, CLK_PIN = 2, TRG_PIN = 3, TX_PIN = 0;

    gp_mode_e        mode;
    logic            clr_dir, clr_dat, wr_ok, ovr_ok;
    logic [NPIN-1:0] dir_q, dat_q, pin_sync;

    gp_mode_fsm u_fsm (
        .clk(clk), .por_n(por_n), .hw_stby(hw_stby), .manual_rst(manual_rst),
        .sw_stby(sw_stby), .mode(mode), .clr_dir(clr_dir), .clr_dat(clr_dat),
        .wr_ok(wr_ok), .ovr_ok(ovr_ok)
    );

    gp_sync #(.NPIN(NPIN), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .por_n(por_n), .d(pin_in), .q(pin_sync)
    );

    gp_regs #(.NPIN(NPIN), .DW(DW), .AW(AW), .A_DIR(A_DIR), .A_DAT(A_DAT), .A_PIN(A_PIN)) u_regs (
        .clk(clk), .por_n(por_n), .clr_dir(clr_dir), .clr_dat(clr_dat), .wr_ok(wr_ok),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .pin_sync(pin_sync), .bus_rdata(bus_rdata), .dir_q(dir_q), .dat_q(dat_q)
    );

    gp_pinmux #(.NPIN(NPIN), .TX_PIN(TX_PIN), .CLK_PIN(CLK_PIN)) u_mux (
        .ovr_ok(ovr_ok), .hstby(mode == ST_HSTBY), .dir_q(dir_q), .dat_q(dat_q),
        .sci_tx_en(sci_tx_en), .sci_txd(sci_txd), .sci_clk_oe(sci_clk_oe),
        .sci_clk_out(sci_clk_out), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    assign sci_rxd    = pin_sync[RX_PIN];
    assign sci_clk_in = pin_sync[CLK_PIN];
    assign conv_trig  = pin_sync[TRG_PIN];
endmodule

// File: rtl/gp_port_chk.sv
module gp_port_chk
    import gp_port_pkg::*;
(
    input logic        clk,
    input logic        por_n,
    input logic        manual_rst,
    input logic        sw_stby,
    input logic        hw_stby,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_rdata,
    input logic [3:0]  pin_in,
    input logic [3:0]  pin_out,
    input logic [3:0]  pin_oe,
    input logic        sci_tx_en,
    input logic        sci_txd,
    input logic        sci_rxd,
    input logic        conv_trig
);
    logic [1:0] age;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)         age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_HSTBY_UNDRIVEN: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |=> pin_oe == 4'h0); // R12

    AST_RSV_ONES: assert property (@(posedge clk) disable iff (!por_n)
        bus_sel |-> bus_rdata[7:4] == 4'hF); // R4

    AST_DIR_READ_FIXED: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && !bus_wr && bus_addr == OFS_DIR) |-> bus_rdata == 8'hFF); // R3

    AST_TX_OVERRIDE: assert property (@(posedge clk) disable iff (!por_n)
        (age != 2'd0 && $past(!hw_stby && !manual_rst && !sw_stby) && sci_tx_en)
            |-> (pin_oe[0] && pin_out[0] == sci_txd)); // R7

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!por_n)
        (age == 2'd3) |-> (sci_rxd == $past(pin_in[1], 2) && conv_trig == $past(pin_in[3], 2))); // R9
endmodule

bind mux_gpio_port gp_port_chk u_chk (
    .clk(clk), .por_n(por_n), .manual_rst(manual_rst), .sw_stby(sw_stby),
    .hw_stby(hw_stby), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .sci_tx_en(sci_tx_en), .sci_txd(sci_txd), .sci_rxd(sci_rxd), .conv_trig(conv_trig)
);

// File: tb/mux_gpio_port_test.sv
module mux_gpio_port_test;
    localparam logic [15:0] A_DIR = 16'hFEB4, A_DAT = 16'hFF64, A_PIN = 16'hFF54;

    logic clk = 1'b0;
    logic por_n = 1'b0, manual_rst = 1'b0, sw_stby = 1'b0, hw_stby = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [3:0] pin_in = '0, pin_out, pin_oe;
    logic sci_tx_en = 1'b0, sci_txd = 1'b0, sci_clk_oe = 1'b0, sci_clk_out = 1'b0;
    logic sci_rxd, sci_clk_in, conv_trig;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    typedef struct {
        int       kind;   // 0 rdata, 1 pin_oe, 2 pin_out, 3 {rxd,clk_in,trig}
        logic [7:0] exp;
        string    req;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    mux_gpio_port uut (
        .clk(clk), .por_n(por_n), .manual_rst(manual_rst), .sw_stby(sw_stby),
        .hw_stby(hw_stby), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .sci_tx_en(sci_tx_en), .sci_txd(sci_txd),
        .sci_clk_oe(sci_clk_oe), .sci_clk_out(sci_clk_out), .sci_rxd(sci_rxd),
        .sci_clk_in(sci_clk_in), .conv_trig(conv_trig)
    );

    // Monitor: compares queued expectations in the middle of the cycle.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = {4'h0, pin_oe};
                    2: act = {4'h0, pin_out};
                    default: act = {5'h0, sci_rxd, sci_clk_in, conv_trig};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic exp_rd(logic [15:0] a, logic [7:0] e, string r);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        sb_q.push_back('{0, e, r});
        tick();
        bus_sel = 1'b0;
    endtask

    task automatic exp_obs(int k, logic [7:0] e, string r);
        sb_q.push_back('{k, e, r});
        tick();
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(2);
        por_n = 1'b1;
        tick();
        // R1 reset state
        exp_obs(1, 8'h00, "R1");
        exp_rd(A_DAT, 8'hF0, "R1");
        exp_rd(A_PIN, 8'hF0, "R1");
        exp_rd(A_DIR, 8'hFF, "R3");
        // R5 / R4 data register and reserved bits
        wr(A_DAT, 8'h05);
        exp_rd(A_DAT, 8'hF5, "R5");
        wr(A_DAT, 8'h0A);
        exp_rd(A_DAT, 8'hFA, "R4");
        wr(16'hFF00, 8'h03);
        exp_rd(A_DAT, 8'hFA, "R5");
        // R2 direction
        wr(A_DIR, 8'h0C);
        exp_obs(1, 8'h0C, "R2");
        exp_obs(2, 8'h0A, "R2");
        exp_rd(A_DIR, 8'hFF, "R3");
        exp_obs(1, 8'h0C, "R3");
        // R6 / R9 pin readback and synchronizer
        pin_in = 4'b0101;
        tick(3);
        exp_rd(A_PIN, 8'hF9, "R6");
        exp_obs(3, 8'h02, "R9");
        pin_in = 4'b1010;
        tick();
        exp_obs(3, 8'h02, "R9");
        tick();
        exp_obs(3, 8'h05, "R9");
        // R7 transmit override
        sci_tx_en = 1'b1; sci_txd = 1'b1;
        tick();
        exp_obs(1, 8'h0D, "R7");
        exp_obs(2, 8'h0B, "R7");
        sci_txd = 1'b0;
        exp_obs(2, 8'h0A, "R7");
        sci_tx_en = 1'b0;
        exp_obs(1, 8'h0C, "R7");
        // R8 clock override
        wr(A_DIR, 8'h00);
        sci_clk_oe = 1'b1; sci_clk_out = 1'b1;
        exp_obs(1, 8'h04, "R8");
        exp_obs(2, 8'h0E, "R8");
        sci_clk_oe = 1'b0;
        exp_obs(1, 8'h00, "R8");
        // R11 software standby
        wr(A_DIR, 8'h03);
        sw_stby = 1'b1;
        tick();
        wr(A_DAT, 8'h00);
        wr(A_DIR, 8'h00);
        sci_tx_en = 1'b1; sci_txd = 1'b1;
        exp_obs(1, 8'h03, "R11");
        exp_obs(2, 8'h0A, "R11");
        exp_rd(A_DAT, 8'hFA, "R11");
        sci_tx_en = 1'b0; sci_txd = 1'b0;
        sw_stby = 1'b0;
        tick();
        // R10 manual reset
        manual_rst = 1'b1;
        tick();
        wr(A_DIR, 8'h00);
        exp_rd(A_DAT, 8'hF0, "R10");
        exp_obs(1, 8'h03, "R10");
        manual_rst = 1'b0;
        tick();
        exp_obs(1, 8'h03, "R10");
        // R12 hardware standby
        wr(A_DAT, 8'h0F);
        hw_stby = 1'b1;
        tick();
        exp_obs(1, 8'h00, "R12");
        hw_stby = 1'b0;
        tick();
        exp_obs(1, 8'h00, "R12");
        exp_rd(A_DAT, 8'hF0, "R12");
        // R13 priority: manual reset beats software standby
        wr(A_DIR, 8'h01);
        wr(A_DAT, 8'h05);
        manual_rst = 1'b1; sw_stby = 1'b1;
        tick(2);
        exp_rd(A_DAT, 8'hF0, "R13");
        hw_stby = 1'b1;
        tick();
        exp_obs(1, 8'h00, "R13");
        hw_stby = 1'b0; manual_rst = 1'b0; sw_stby = 1'b0;
        tick(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule